// File: doc/BRIEF.md
# Endian-Selectable Byte-Lane Memory Port

This block connects the load/store stage of a 32-bit processor to a data memory that is 32 bits wide and byte addressed. For a store, it turns an access size and an address into a 4-bit lane-enable mask. It also places the store data on the write bus so that every enabled lane carries the correct byte. For a load, it takes the word the memory returns one cycle later, picks the addressed lanes, puts them in order and sign- or zero-extends the result to 32 bits.

The byte ordering is chosen by a mode input. With the input high, the most significant byte of a multi-byte item sits at the lowest address. With it low, the least significant byte sits there. The block does not split a halfword or word access that crosses its natural boundary. It raises a misalignment flag for that access and sends nothing to the memory.

Top module: `lane_port`

## Requirements
- R1: Byte address A lives in lane A mod 4 of the memory word. Lane k is bits 8k+7:8k. For every accepted access, `mem_addr_o` equals `addr_i` with bits 1:0 cleared.
- R2: `size_i` encodes 0 = byte, 1 = halfword, 2 = word, 3 = word. A byte store enables exactly lane `addr_i[1:0]` and drives `wdata_i[7:0]` on that lane.
- R3: A halfword store enables lanes 0 and 1, or lanes 2 and 3. In little-endian mode the lower-addressed lane receives `wdata_i[7:0]`. In big-endian mode it receives `wdata_i[15:8]`.
- R4: A word store enables all four lanes. In big-endian mode, storing 0x87654321 at address 0 leaves 0x87, 0x65, 0x43, 0x21 at addresses 0 to 3. In little-endian mode it leaves 0x21, 0x43, 0x65, 0x87.
- R5: A halfword request with `addr_i[0]`=1 is misaligned, and so is a word request with `addr_i[1:0]`≠0. In the same cycle the block drives `misalign_o` high, drives `mem_req_o` low and holds `mem_be_o` at 0. No load result follows a misaligned request.
- R6: `rvalid_o` pulses high in the cycle after each accepted load request, and only then. `rdata_o` is valid while `rvalid_o` is high.
- R7: A byte load returns the addressed byte. It is sign-extended when `unsigned_i`=0 and zero-extended when `unsigned_i`=1.
- R8: A halfword load assembles its two bytes in the order set by the mode, then extends the result as in R7.
- R9: A word load assembles all four bytes in the order set by the mode.
- R10: The byte order is taken from `big_end_i` in the request cycle. Reading data back with the other mode gives the bytes reordered.
- R11: After reset, `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_end_i | input | 1 | 1 selects big-endian byte order, 0 selects little-endian |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | Zero-extend a sub-word load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data, right-aligned |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Lane-enable mask |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_rdata_i | input | 32 | Read word, returned one cycle after the request |
| misalign_o | output | 1 | Request rejected as misaligned |
| rvalid_o | output | 1 | Load result valid |
| rdata_o | output | 32 | Extended load result |

## Verification
The bench stores a value in one mode and reads it back in the other. A design that took its byte order from the wrong cycle, or reversed only some of the lanes, returns a scrambled word. Signed loads use bytes and halfwords whose top bit is set. A swapped extension rule would then give 0x000000xx where 0xFFFFFFxx is expected, or the other way round.

The bench sends halfword and word requests at every odd or unaligned offset. A design with a loose alignment test would write lanes it must not touch, and the next read of those lanes would show the corruption. Loads run back to back, so a result that came a cycle late or early, or took the offset of the wrong request, shows up at once.

// File: rtl/lane_port_pkg.sv
package lane_port_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
  parameter int OFF_W = 2
) (
  input  lane_port_pkg::acc_size_e size_i,
  input  logic [OFF_W-1:0]         off_i,
  output logic                     bad_o
);
  import lane_port_pkg::*;
  always_comb begin
    unique case (size_i)
      SZ_BYTE: bad_o = 1'b0;
      SZ_HALF: bad_o = off_i[0];
      default: bad_o = |off_i;
    endcase
  end
endmodule

// File: rtl/lane_store.sv
module lane_store #(
  parameter int NB    = 4,
  parameter int OFF_W = $clog2(NB)
) (
  input  lane_port_pkg::acc_size_e size_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic                     big_i,
  input  logic [8*NB-1:0]          wdata_i,
  output logic [NB-1:0]            be_o,
  output logic [8*NB-1:0]          lanes_o
);
  import lane_port_pkg::*;
  localparam logic [NB-1:0] ONE = NB'(1);
  localparam logic [NB-1:0] TWO = NB'(3);

  always_comb begin
    unique case (size_i)
      SZ_BYTE: be_o = ONE << off_i;
      SZ_HALF: be_o = TWO << off_i;
      default: be_o = '1;
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam bit EVEN = (i % 2) == 0;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: lanes_o[8*i +: 8] = wdata_i[7:0];
        // lower-addressed lane of a pair takes the low byte only in little-endian
        SZ_HALF: lanes_o[8*i +: 8] = (EVEN != big_i) ? wdata_i[7:0] : wdata_i[15:8];
        default: lanes_o[8*i +: 8] = big_i ? wdata_i[8*(NB-1-i) +: 8] : wdata_i[8*i +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lane_load.sv
module lane_load #(
  parameter int NB    = 4,
  parameter int OFF_W = $clog2(NB)
) (
  input  lane_port_pkg::acc_size_e size_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic                     big_i,
  input  logic                     uns_i,
  input  logic [8*NB-1:0]          rdata_i,
  output logic [8*NB-1:0]          data_o
);
  import lane_port_pkg::*;
  localparam int DW = 8 * NB;

  logic [7:0]    sel_b;
  logic [7:0]    lo_b, hi_b;
  logic [OFF_W-1:0] off_e, off_o;
  logic [DW-1:0] word_v;

  assign off_e = {off_i[OFF_W-1:1], 1'b0};
  assign off_o = {off_i[OFF_W-1:1], 1'b1};
  assign sel_b = rdata_i[8*off_i +: 8];
  assign lo_b  = big_i ? rdata_i[8*off_o +: 8] : rdata_i[8*off_e +: 8];
  assign hi_b  = big_i ? rdata_i[8*off_e +: 8] : rdata_i[8*off_o +: 8];

  for (genvar i = 0; i < NB; i++) begin : g_word
    assign word_v[8*i +: 8] = big_i ? rdata_i[8*(NB-1-i) +: 8] : rdata_i[8*i +: 8];
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DW-8){sel_b[7] & ~uns_i}}, sel_b};
      SZ_HALF: data_o = {{(DW-16){hi_b[7] & ~uns_i}}, hi_b, lo_b};
      default: data_o = word_v;
    endcase
  end
endmodule

// File: rtl/lane_port.sv
module lane_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_end_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              misalign_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  import lane_port_pkg::*;
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  acc_size_e        size_c;
  logic [OFF_W-1:0] off_c;
  logic             bad_c, ok_c;
  logic [NB-1:0]    be_c;

  acc_size_e        ld_size_q;
  logic [OFF_W-1:0] ld_off_q;
  logic             ld_big_q, ld_uns_q, ld_pend_q;

  assign size_c = acc_size_e'(size_i);
  assign off_c  = addr_i[OFF_W-1:0];

  lane_align_chk #(.OFF_W(OFF_W)) u_align (
    .size_i (size_c),
    .off_i  (off_c),
    .bad_o  (bad_c)
  );

  lane_store #(.NB(NB), .OFF_W(OFF_W)) u_store (
    .size_i  (size_c),
    .off_i   (off_c),
    .big_i   (big_end_i),
    .wdata_i (wdata_i),
    .be_o    (be_c),
    .lanes_o (mem_wdata_o)
  );

  assign ok_c       = req_i & ~bad_c;
  assign misalign_o = req_i & bad_c;
  assign mem_req_o  = ok_c;
  assign mem_we_o   = ok_c & we_i;
  assign mem_be_o   = (ok_c & we_i) ? be_c : '0;
  assign mem_addr_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      ld_size_q <= SZ_BYTE;
      ld_off_q  <= '0;
      ld_big_q  <= 1'b0;
      ld_uns_q  <= 1'b0;
    end else begin
      ld_pend_q <= ok_c & ~we_i;
      if (ok_c && !we_i) begin
        ld_size_q <= size_c;
        ld_off_q  <= off_c;
        ld_big_q  <= big_end_i;
        ld_uns_q  <= unsigned_i;
      end
    end
  end

  lane_load #(.NB(NB), .OFF_W(OFF_W)) u_load (
    .size_i  (ld_size_q),
    .off_i   (ld_off_q),
    .big_i   (ld_big_q),
    .uns_i   (ld_uns_q),
    .rdata_i (mem_rdata_i),
    .data_o  (rdata_o)
  );

  assign rvalid_o = ld_pend_q;
endmodule

// File: rtl/lane_port_sva.sv
module lane_port_sva #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic              misalign_o,
  input logic              rvalid_o
);
  logic ld_acc;
  assign ld_acc = req_i && !we_i && !misalign_o;

  // R5
  misalign_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_be_o == '0 && !mem_req_o));

  // R6
  load_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_acc |=> rvalid_o);

  // R6
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_acc |=> !rvalid_o);

  // R2
  byte_one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == 2'd0) |-> $countones(mem_be_o) == 1);

  // R4
  word_all_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && we_i && size_i[1]) |-> (&mem_be_o));

  // R1
  word_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && mem_addr_o[ADDR_W-1:2] == addr_i[ADDR_W-1:2]));
endmodule

bind lane_port lane_port_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .size_i     (size_i),
  .addr_i     (addr_i),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .misalign_o (misalign_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/lane_port_tb_top.sv
module lane_port_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_end, req, we, uns;
  logic [1:0]  size;
  logic [31:0] addr, wdata;
  logic        mem_req, mem_we, misalign, rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rdata;
  logic [3:0]  mem_be;

  int checks = 0;
  int fails  = 0;

  logic [31:0] ram [16];
  logic [31:0] rd_q;
  logic [7:0]  rb [64];

  bit          exp_v = 1'b0;
  logic [31:0] exp_d = '0;
  string       exp_tag = "R6";

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .big_end_i(big_end), .req_i(req), .we_i(we),
    .size_i(size), .unsigned_i(uns), .addr_i(addr), .wdata_i(wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .misalign_o(misalign),
    .rvalid_o(rvalid), .rdata_o(rdata)
  );

  // synchronous RAM model
  always_ff @(posedge clk) begin
    if (mem_req) begin
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) ram[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      rd_q <= ram[mem_addr[5:2]];
    end
  end
  assign mem_rdata = rd_q;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nbytes(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ref_load(int a, int sz, bit u, bit big);
    int n = nbytes(sz);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) begin
      int pos = big ? (n - 1 - i) : i;
      v[8*pos +: 8] = rb[a + i];
    end
    if (n < 4 && !u && v[8*n-1])
      for (int j = 8*n; j < 32; j++) v[j] = 1'b1;
    return v;
  endfunction

  task automatic step(bit rq, bit w, int sz, bit u, int a, logic [31:0] wd, bit big);
    bit mis;
    int n;
    logic [3:0] ebe;
    // result of the previous cycle's request
    check(rvalid == exp_v, "R6", {31'b0, rvalid}, {31'b0, exp_v});
    if (exp_v) check(rdata == exp_d, exp_tag, rdata, exp_d);
    req = rq; we = w; size = sz[1:0]; uns = u; addr = a; wdata = wd; big_end = big;
    #1;
    n   = nbytes(sz);
    mis = rq && ((n == 2 && a[0]) || (n == 4 && a[1:0] != 0));
    check(misalign == mis, "R5", {31'b0, misalign}, {31'b0, mis});
    if (mis) check(mem_be == 0 && !mem_req, "R5", {27'b0, mem_req, mem_be}, 32'h0);
    if (rq && !mis) check(mem_addr == {addr[31:2], 2'b00}, "R1", mem_addr, {addr[31:2], 2'b00});
    if (rq && w && !mis) begin
      ebe = (n == 1) ? 4'b0001 << a[1:0] : (n == 2) ? 4'b0011 << a[1:0] : 4'b1111;
      check(mem_be == ebe, (n == 1) ? "R2" : (n == 2) ? "R3" : "R4", {28'b0, mem_be}, {28'b0, ebe});
      for (int i = 0; i < n; i++) begin
        int pos = big ? (n - 1 - i) : i;
        rb[a + i] = wd[8*pos +: 8];
      end
    end
    exp_v = rq && !w && !mis;
    if (exp_v) begin
      exp_d   = ref_load(a, sz, u, big);
      exp_tag = (n == 1) ? "R7" : (n == 2) ? "R8" : "R9";
    end
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    req = 0; we = 0; size = 0; uns = 0; addr = 0; wdata = 0; big_end = 0;
    for (int i = 0; i < 16; i++) ram[i] = '0;
    for (int i = 0; i < 64; i++) rb[i] = '0;
    repeat (3) @(negedge clk);
    // R11
    check(rvalid == 1'b0, "R11", {31'b0, rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rvalid == 1'b0 && misalign == 1'b0, "R11", {30'b0, rvalid, misalign}, 32'h0);

    // R4 example in both orders; R9 word readback
    step(1, 1, 2, 0, 0, 32'h87654321, 0);
    step(1, 1, 2, 0, 4, 32'h87654321, 1);
    idle();
    check(ram[0] == 32'h87654321, "R4", ram[0], 32'h87654321);
    check(ram[1] == 32'h21436587, "R4", ram[1], 32'h21436587);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 1, i, 0, 0);   // R7 unsigned bytes
    step(1, 0, 2, 0, 0, 0, 0);
    step(1, 0, 2, 0, 4, 0, 1);
    // R10: read back in the opposite order
    step(1, 0, 2, 0, 0, 0, 1);
    step(1, 0, 2, 0, 4, 0, 0);

    // R2/R3 sub-word stores, R7/R8 signed and unsigned loads
    step(1, 1, 0, 0, 9,  32'hxxxx_xx9c, 0);
    step(1, 1, 1, 0, 10, 32'h0000_80f1, 0);
    step(1, 1, 1, 0, 12, 32'h0000_f17e, 1);
    step(1, 1, 0, 0, 15, 32'h0000_0083, 1);
    for (int u = 0; u < 2; u++) begin
      for (int b = 0; b < 2; b++) begin
        step(1, 0, 0, u[0], 9,  0, b[0]);
        step(1, 0, 1, u[0], 10, 0, b[0]);
        step(1, 0, 1, u[0], 12, 0, b[0]);
        step(1, 0, 0, u[0], 15, 0, b[0]);
      end
    end

    // R5 misaligned stores and loads, then confirm nothing was written
    step(1, 1, 1, 0, 17, 32'hdead_beef, 0);
    step(1, 1, 2, 0, 18, 32'hdead_beef, 1);
    step(1, 1, 3, 0, 19, 32'hdead_beef, 0);
    step(1, 0, 1, 0, 21, 0, 0);
    step(1, 0, 2, 0, 22, 0, 1);
    step(1, 0, 2, 0, 16, 0, 0);
    step(1, 0, 2, 0, 20, 0, 0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int a  = $urandom_range(0, 63);
      int sz = $urandom_range(0, 3);
      if (nbytes(sz) > 1 && $urandom_range(0, 3) != 0) a = a & ~(nbytes(sz) - 1);
      if (a + nbytes(sz) > 64) a = 64 - nbytes(sz);
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, sz,
           $urandom_range(0, 1) == 1, a, $urandom, $urandom_range(0, 1) == 1);
    end
    idle();
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule